// File: doc/BRIEF.md
# Console Character Register Interface

This block gives software a console channel through four 16-bit registers on a simple memory-mapped bus. The receive half takes 8-bit characters from a valid strobe, holds the latest one, flags it ready and can raise an interrupt. The transmit half takes a byte written by software, offers its low seven bits to a downstream serializer through a valid/ready handshake, and flags completion once the serializer takes the character. Bit-level line coding happens elsewhere: on both sides a character is a single word.

Each half has a status word with a ready flag and an interrupt enable, and a buffer word. The interrupt line of each half is high exactly while its ready flag and its enable are both set. Reads are combinational on `bus_rdata`, and the one read with a side effect (the receive buffer) acts on the clock edge of the access.

Top module: `console_term`

## Requirements
- R1: `bus_addr[2:1]` selects the register: 0 receive status, 1 receive buffer, 2 transmit status, 3 transmit buffer. A status word reads the ready flag on bit 7 and the enable on bit 6, with every other bit zero; the receive buffer reads the held character zero-extended; the transmit buffer reads the last byte loaded.
- R2: Only the enable (bit 6) of a status word is writable, and only by a write with `bus_addr[0]`=0; a write with `bus_addr[0]`=1 to a status word changes nothing, and bit 7 of the written data never alters the ready flag.
- R3: A cycle with `rx_valid` high stores `rx_data` in the receive buffer and sets the receive ready flag, replacing an unread character without any overrun indication.
- R4: A read of the receive buffer clears the receive ready flag unless a character arrives in the same cycle, in which case the flag stays set; writes to the receive buffer have no effect.
- R5: A write to the transmit buffer clears the transmit ready flag and raises `tx_valid` on the next cycle; with `bus_addr[0]`=0 it loads `bus_wdata[7:0]`, with `bus_addr[0]`=1 it keeps the stored byte and sends it again.
- R6: `tx_valid` and `tx_data` hold steady until `tx_ready` is seen high; the cycle after that handshake `tx_valid` is low and the transmit ready flag is set. `tx_data` carries bits 6:0 of the stored byte.
- R7: `irq_rx` and `irq_tx` are high exactly while the matching ready flag and enable are both set: setting the enable while ready is set raises the line on the next cycle, and clearing the enable withdraws it.
- R8: After reset both receive registers read zero, the transmit status reads only the ready flag (0x0080), `tx_valid` is low and both interrupt lines are low.
- R9: A transmit buffer write in the same cycle as a handshake on the previous character wins: the new character is pending and the ready flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Byte address within the block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rx_valid | input | 1 | Incoming character strobe |
| rx_data | input | 8 | Incoming character |
| tx_valid | output | 1 | Outgoing character pending |
| tx_ready | input | 1 | Serializer takes the character |
| tx_data | output | 7 | Outgoing character |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The hardest situations to reach are the same-cycle collisions: a character arriving in the very cycle software reads the receive buffer, and a new transmit write landing in the cycle the serializer accepts the previous character. The bench drives these by placing the bus access and the strobe or ready on the same falling edge, so both are seen by one rising edge, and then inspects the ready flags and the handshake outputs one cycle later. The odd-byte transmit write is reached by first loading a known byte and then checking that an odd write resends it unchanged.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int STAT_READY_BIT  = 7;
  localparam int STAT_ENABLE_BIT = 6;

  typedef enum logic [1:0] {
    REG_RX_STAT = 2'd0,
    REG_RX_BUF  = 2'd1,
    REG_TX_STAT = 2'd2,
    REG_TX_BUF  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/console_rx_chan.sv
module console_rx_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              buf_rd,
  input  logic              en_wr,
  input  logic              en_val,
  output logic              ready_q,
  output logic              en_q,
  output logic [CHAR_W-1:0] buf_q,
  output logic              irq
);
  logic              ready_d;
  logic              en_d;
  logic [CHAR_W-1:0] buf_d;

  always_comb begin
    ready_d = ready_q;
    en_d    = en_q;
    buf_d   = buf_q;
    if (en_wr) en_d = en_val;
    if (buf_rd) ready_d = 1'b0;
    if (in_valid) begin
      buf_d   = in_char;
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      en_q    <= 1'b0;
      buf_q   <= '0;
    end else begin
      ready_q <= ready_d;
      en_q    <= en_d;
      if (in_valid) buf_q <= buf_d;
    end
  end

  assign irq = ready_q & en_q;
endmodule

// File: rtl/console_tx_chan.sv
module console_tx_chan #(
  parameter int CHAR_W = 8,
  parameter int OUT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_byte,
  input  logic [CHAR_W-1:0] load_char,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              out_ready,
  output logic              ready_q,
  output logic              en_q,
  output logic [CHAR_W-1:0] buf_q,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_char,
  output logic              irq
);
  logic              ready_d;
  logic              en_d;
  logic              pend_q;
  logic              pend_d;
  logic [CHAR_W-1:0] buf_d;
  logic              take;

  assign take = pend_q & out_ready;

  always_comb begin
    ready_d = ready_q;
    en_d    = en_q;
    pend_d  = pend_q;
    buf_d   = buf_q;
    if (en_wr) en_d = en_val;
    if (take) begin
      pend_d  = 1'b0;
      ready_d = 1'b1;
    end
    if (load) begin
      pend_d  = 1'b1;
      ready_d = 1'b0;
      if (load_byte) buf_d = load_char;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      buf_q   <= '0;
    end else begin
      ready_q <= ready_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
      if (load_byte) buf_q <= buf_d;
    end
  end

  assign out_valid = pend_q;
  assign out_char  = buf_q[OUT_W-1:0];
  assign irq       = ready_q & en_q;
endmodule

// File: rtl/console_term.sv
module console_term #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter int OUT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [OUT_W-1:0]  tx_data,
  output logic              irq_rx,
  output logic              irq_tx
);
  import console_pkg::*;

  localparam int PAD_W = DATA_W - CHAR_W;

  reg_sel_e          sel;
  logic              odd;
  logic              wr_even;
  logic              rx_en_wr;
  logic              tx_en_wr;
  logic              rx_buf_rd;
  logic              tx_load;
  logic              tx_load_byte;
  logic              en_bit;
  logic              rx_done;
  logic              rx_ie;
  logic              tx_done;
  logic              tx_ie;
  logic [CHAR_W-1:0] rx_buf_q;
  logic [CHAR_W-1:0] tx_buf_q;
  logic [DATA_W-1:0] rx_stat;
  logic [DATA_W-1:0] tx_stat;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(bus_addr[2:1]);
  assign odd          = bus_addr[0];
  assign wr_even      = bus_sel & bus_wr & ~odd;
  assign rx_en_wr     = wr_even & (sel == REG_RX_STAT);
  assign tx_en_wr     = wr_even & (sel == REG_TX_STAT);
  assign rx_buf_rd    = bus_sel & ~bus_wr & (sel == REG_RX_BUF);
  assign tx_load      = bus_sel & bus_wr & (sel == REG_TX_BUF);
  assign tx_load_byte = tx_load & ~odd;
  assign en_bit       = bus_wdata[STAT_ENABLE_BIT];
  assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

  console_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_char  (rx_data),
    .buf_rd   (rx_buf_rd),
    .en_wr    (rx_en_wr),
    .en_val   (en_bit),
    .ready_q  (rx_done),
    .en_q     (rx_ie),
    .buf_q    (rx_buf_q),
    .irq      (irq_rx)
  );

  console_tx_chan #(.CHAR_W(CHAR_W), .OUT_W(OUT_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_byte (tx_load_byte),
    .load_char (bus_wdata[CHAR_W-1:0]),
    .en_wr     (tx_en_wr),
    .en_val    (en_bit),
    .out_ready (tx_ready),
    .ready_q   (tx_done),
    .en_q      (tx_ie),
    .buf_q     (tx_buf_q),
    .out_valid (tx_valid),
    .out_char  (tx_data),
    .irq       (irq_tx)
  );

  always_comb begin
    rx_stat = '0;
    rx_stat[STAT_READY_BIT]  = rx_done;
    rx_stat[STAT_ENABLE_BIT] = rx_ie;
    tx_stat = '0;
    tx_stat[STAT_READY_BIT]  = tx_done;
    tx_stat[STAT_ENABLE_BIT] = tx_ie;
  end

  always_comb begin
    unique case (sel)
      REG_RX_STAT: bus_rdata = rx_stat;
      REG_RX_BUF:  bus_rdata = {{PAD_W{1'b0}}, rx_buf_q};
      REG_TX_STAT: bus_rdata = tx_stat;
      REG_TX_BUF:  bus_rdata = {{PAD_W{1'b0}}, tx_buf_q};
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/console_term_sva.sv
module console_term_sva #(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter int OUT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [OUT_W-1:0]  tx_data,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              rx_done,
  input logic              rx_ie,
  input logic              tx_done,
  input logic              tx_ie,
  input logic [CHAR_W-1:0] rx_buf_q
);
  logic rbuf_rd, tbuf_wr, rstat_odd, rstat_en_set, tstat_en_set;
  assign rbuf_rd      = bus_sel && !bus_wr && bus_addr[2:1] == 2'd1;
  assign tbuf_wr      = bus_sel && bus_wr && bus_addr[2:1] == 2'd3;
  assign rstat_odd    = bus_sel && bus_wr && bus_addr == 3'd1;
  assign rstat_en_set = bus_sel && bus_wr && bus_addr == 3'd0 && bus_wdata[6];
  assign tstat_en_set = bus_sel && bus_wr && bus_addr == 3'd4 && bus_wdata[6];

  a_r3_arrival_latches: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_done && rx_buf_q == $past(rx_data));

  a_r4_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rbuf_rd && !rx_valid) |=> !rx_done && !irq_rx);

  a_r2_odd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rstat_odd && !rx_valid && !rbuf_rd) |=> $stable(rx_ie) && $stable(rx_done));

  a_r5_load_starts_output: assert property (@(posedge clk) disable iff (!rst_n)
    tbuf_wr |=> tx_valid && !tx_done && !irq_tx);

  a_r6_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tbuf_wr) |=> tx_valid && $stable(tx_data));

  a_r6_take_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !tbuf_wr) |=> !tx_valid && tx_done);

  a_r7_rx_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx) |-> $past(rx_valid) || $past(rstat_en_set));

  a_r7_tx_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> ($past(tx_valid) && $past(tx_ready)) || $past(tstat_en_set));

  a_r7_tx_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> tx_ie && tx_done);
endmodule

bind console_term console_term_sva #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .OUT_W(OUT_W)) u_sva (.*);

// File: tb/console_term_test.sv
module console_term_test;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [6:0]  tx_data;
  logic        irq_rx;
  logic        irq_tx;

  int checks = 0;
  int fails  = 0;

  console_term uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic push(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); check(v == 16'h0000, "R8 rx status", v, 16'h0000);
    rd(3'd2, v); check(v == 16'h0000, "R8 rx buffer", v, 16'h0000);
    rd(3'd4, v); check(v == 16'h0080, "R8 tx status", v, 16'h0080);
    check(!tx_valid && !irq_rx && !irq_tx, "R8 outputs idle",
          {13'd0, tx_valid, irq_rx, irq_tx}, 16'h0000);
  endtask

  task automatic t_rx_basic();
    logic [15:0] v;
    push(8'hA5);
    rd(3'd0, v); check(v == 16'h0080, "R3 ready after arrival", v, 16'h0080);
    rd(3'd2, v); check(v == 16'h00A5, "R1 R3 rx buffer value", v, 16'h00A5);
    rd(3'd0, v); check(v == 16'h0000, "R4 ready cleared by read", v, 16'h0000);
  endtask

  task automatic t_rx_overwrite();
    logic [15:0] v;
    push(8'h11);
    push(8'hF2);
    rd(3'd2, v); check(v == 16'h00F2, "R3 unread char replaced", v, 16'h00F2);
    wr(3'd2, 16'h0033);
    push(8'h44);
    wr(3'd2, 16'h00EE);
    rd(3'd0, v); check(v == 16'h0080, "R4 rx buffer write keeps ready", v, 16'h0080);
    rd(3'd2, v); check(v == 16'h0044, "R4 rx buffer write ignored", v, 16'h0044);
  endtask

  task automatic t_rx_collide();
    logic [15:0] v;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd2;
    rx_valid = 1'b1; rx_data = 8'h5A;
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
    rd(3'd0, v); check(v == 16'h0080, "R4 arrival beats read", v, 16'h0080);
    rd(3'd2, v); check(v == 16'h005A, "R4 arrival char kept", v, 16'h005A);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    push(8'h01);
    check(!irq_rx, "R7 no irq while disabled", {15'd0, irq_rx}, 16'h0000);
    wr(3'd1, 16'h0040);
    check(!irq_rx, "R2 odd status write ignored", {15'd0, irq_rx}, 16'h0000);
    wr(3'd0, 16'h0000 | 16'h0040 | 16'h0000);
    check(irq_rx, "R7 enable with ready raises irq", {15'd0, irq_rx}, 16'h0001);
    rd(3'd0, v); check(v == 16'h00C0, "R1 R2 rx status enable bit", v, 16'h00C0);
    wr(3'd0, 16'h0000);
    check(!irq_rx, "R7 clearing enable withdraws", {15'd0, irq_rx}, 16'h0000);
    wr(3'd0, 16'h0040);
    rd(3'd2, v);
    check(!irq_rx, "R4 R7 read drops irq", {15'd0, irq_rx}, 16'h0000);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); check(v == 16'h0080, "R2 ready bit not writable", v, 16'h0080);
    wr(3'd4, 16'h0040);
    check(irq_tx, "R7 tx enable with ready", {15'd0, irq_tx}, 16'h0001);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_tx();
    logic [15:0] v;
    wr(3'd6, 16'h12C1);
    check(tx_valid && tx_data == 7'h41, "R5 R6 output pending 7 bits",
          {8'd0, tx_valid, tx_data}, 16'h00C1);
    check(!irq_tx, "R5 irq cleared on load", {15'd0, irq_tx}, 16'h0000);
    rd(3'd4, v); check(v == 16'h0040, "R5 tx ready cleared", v, 16'h0040);
    rd(3'd6, v); check(v == 16'h00C1, "R1 tx buffer reads back", v, 16'h00C1);
    repeat (3) @(negedge clk);
    check(tx_valid && tx_data == 7'h41, "R6 held without ready",
          {8'd0, tx_valid, tx_data}, 16'h00C1);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check(!tx_valid && irq_tx, "R6 R7 taken sets ready and irq",
          {14'd0, tx_valid, irq_tx}, 16'h0001);
    wr(3'd7, 16'h0055);
    rd(3'd6, v); check(v == 16'h00C1, "R5 odd write keeps byte", v, 16'h00C1);
    check(tx_valid && tx_data == 7'h41, "R5 odd write resends",
          {8'd0, tx_valid, tx_data}, 16'h00C1);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_tx_collide();
    logic [15:0] v;
    @(negedge clk);
    tx_ready = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 16'h0037;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tx_ready = 1'b0;
    check(tx_valid && tx_data == 7'h37, "R9 new char pending",
          {8'd0, tx_valid, tx_data}, 16'h00B7);
    rd(3'd4, v); check(v == 16'h0000, "R9 ready stays clear", v, 16'h0000);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    rd(3'd4, v); check(v == 16'h0080 && !tx_valid, "R6 second char taken", v, 16'h0080);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0;
    bus_wdata = 16'h0000; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_basic();
    t_rx_overwrite();
    t_rx_collide();
    t_enable();
    t_tx();
    t_tx_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule